// File: doc/BRIEF.md
# Banked Edge-Triggered External Interrupt Controller

This block turns up to 96 asynchronous external lines into interrupt requests. The lines are grouped in banks of 32. Line n belongs to bank n/32 at bit n%32. Each line is first brought into the clock domain by a two-flop synchronizer. An edge detector then compares the current synchronized sample with the previous one. Software enables rising and falling edges separately for each line, so a line can respond to rising edges, falling edges or both.

A detected rising edge sets the line's rising pending bit, and a falling edge sets its falling pending bit. Both pending registers are write-1-to-clear, and the two are cleared independently. A software trigger register can raise a line's rising pending bit. An interrupt mask gates the pending state onto one level output per line, and an aggregate output is the OR of those lines. A separate event mask produces a one-cycle event pulse for each detected edge or software trigger.

Software reaches the registers through a plain 32-bit read/write port. Writes take effect on a single clock edge. Read data is combinational from the address. One parameter states which lines exist in each bank. Bits for lines that do not exist read as 0 and cannot be set.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, and irq_o, irq_any_o and evt_o are all low.
- R2: Only word-aligned addresses (addr[1:0]=0) decode. Bank b has its trigger window at byte b*0x20 with five registers: +0x00 rising select, +0x04 falling select, +0x08 software trigger, +0x0C rising pending, +0x10 falling pending. Its mask window is at 0x80+b*0x10 with two registers: +0x0 interrupt mask, +0x4 event mask. Every other address reads 0 and ignores writes.
- R3: When a line goes from 0 to 1 with its rising select bit set, its rising pending bit reads 1 after the third rising clock edge following the change, and not earlier.
- R4: When a line goes from 1 to 0 with its falling select bit set, its falling pending bit becomes 1 with the same latency. With both select bits set, both pending bits are captured.
- R5: An edge whose select bit is 0 leaves both pending registers unchanged.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Clearing a rising pending bit does not touch the falling pending bit, and the reverse holds too.
- R7: If an edge is detected on the same clock edge as a write that clears that pending bit, the bit stays set.
- R8: Writing 1 to a software trigger bit sets that line's rising pending bit only if its rising select bit is 1. Writing 0 has no effect. The software trigger register always reads 0.
- R9: Parameter IMPL_MASK lists the lines that exist in each bank. Its default is 0xFFFFFFFF for bank 0, 0x00FFFFFF for bank 1 and 0x000003FF for bank 2. Bits for absent lines read 0 in every register and never become pending. Writing all ones to a select register and reading it back returns the bank's mask.
- R10: irq_o[n] is high exactly while line n has a rising or falling pending bit set and its interrupt mask bit is 1. A masked line still latches pending.
- R11: irq_any_o is high exactly while some bit of irq_o is high.
- R12: evt_o[n] pulses high for one cycle, in the cycle after a pending set caused by an edge or software trigger, if the event mask bit of line n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 96 | Asynchronous external lines |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 8 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from reg_addr_i |
| irq_o | output | 96 | Per-line interrupt level |
| irq_any_o | output | 1 | OR of all per-line interrupts |
| evt_o | output | 96 | Per-line one-cycle event pulse |

## Verification
The hardest case to reach from the ports is the collision between a freshly detected edge and a clear write to the same pending bit. The edge appears only after the synchronizer delay, so the write has to land on exactly the clock edge where the detector fires. The stimulus changes the line on a falling clock edge, lets two rising edges pass, and then asserts the clear write for one cycle so that it meets the detection edge. Random sequences of configuration writes, line changes, clears and software triggers are checked against a bench register model once the synchronizer has settled.

// File: rtl/exti_pkg.sv
`timescale 1ns/1ps
package exti_pkg;
  localparam int BANK_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int BANK_IDX_W = 2;

  typedef enum logic [2:0] {
    REG_RSEL  = 3'd0,
    REG_FSEL  = 3'd1,
    REG_SWT   = 3'd2,
    REG_RPEND = 3'd3,
    REG_FPEND = 3'd4,
    REG_IMR   = 3'd5,
    REG_EMR   = 3'd6,
    REG_NONE  = 3'd7
  } reg_e;

  typedef struct packed {
    logic rsel;
    logic fsel;
    logic swt;
    logic rclr;
    logic fclr;
    logic imr;
    logic emr;
  } bank_wr_t;

  typedef struct packed {
    logic [BANK_W-1:0] rsel;
    logic [BANK_W-1:0] fsel;
    logic [BANK_W-1:0] rpend;
    logic [BANK_W-1:0] fpend;
    logic [BANK_W-1:0] imr;
    logic [BANK_W-1:0] emr;
  } bank_regs_t;
endpackage

// File: rtl/exti_sync.sv
`timescale 1ns/1ps
module exti_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/exti_decode.sv
`timescale 1ns/1ps
module exti_decode import exti_pkg::*; #(
  parameter int NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic                  hit_o,
  output logic [BANK_IDX_W-1:0] bank_o,
  output reg_e                  reg_o
);
  // trigger window: addr[7]=0, bank in [6:5]; mask window: addr[7:6]=2'b10, bank in [5:4]
  always_comb begin
    bank_o = '0;
    reg_o  = REG_NONE;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i[7]) begin
        if (!addr_i[6] && !addr_i[3]) begin
          bank_o = addr_i[5:4];
          reg_o  = addr_i[2] ? REG_EMR : REG_IMR;
        end
      end else begin
        bank_o = addr_i[6:5];
        unique case (addr_i[4:2])
          3'd0:    reg_o = REG_RSEL;
          3'd1:    reg_o = REG_FSEL;
          3'd2:    reg_o = REG_SWT;
          3'd3:    reg_o = REG_RPEND;
          3'd4:    reg_o = REG_FPEND;
          default: reg_o = REG_NONE;
        endcase
      end
    end
    hit_o = (reg_o != REG_NONE) && (int'(bank_o) < NUM_BANKS);
  end
endmodule

// File: rtl/exti_bank.sv
`timescale 1ns/1ps
module exti_bank import exti_pkg::*; #(
  parameter logic [BANK_W-1:0] IMPL   = '1,
  parameter int                STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] line_i,
  input  bank_wr_t          wr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output bank_regs_t        regs_o,
  output logic [BANK_W-1:0] irq_o,
  output logic [BANK_W-1:0] evt_o
);
  logic [BANK_W-1:0] sync_s, prev_q;
  logic [BANK_W-1:0] rsel_q, fsel_q, imr_q, emr_q, rpend_q, fpend_q, evt_q;
  logic [BANK_W-1:0] rise_ev, fall_ev, sw_ev, rclr, fclr;

  exti_sync #(.WIDTH(BANK_W), .STAGES(STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (sync_s)
  );

  always_comb begin
    rise_ev = sync_s & ~prev_q & rsel_q;
    fall_ev = ~sync_s & prev_q & fsel_q;
    sw_ev   = wr_i.swt  ? (wdata_i & rsel_q) : '0;
    rclr    = wr_i.rclr ? wdata_i : '0;
    fclr    = wr_i.fclr ? wdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      rsel_q  <= '0;
      fsel_q  <= '0;
      imr_q   <= '0;
      emr_q   <= '0;
      rpend_q <= '0;
      fpend_q <= '0;
      evt_q   <= '0;
    end else begin
      prev_q <= sync_s;
      if (wr_i.rsel) rsel_q <= wdata_i & IMPL;
      if (wr_i.fsel) fsel_q <= wdata_i & IMPL;
      if (wr_i.imr)  imr_q  <= wdata_i & IMPL;
      if (wr_i.emr)  emr_q  <= wdata_i & IMPL;
      // set has priority over clear
      rpend_q <= (rpend_q & ~rclr) | rise_ev | sw_ev;
      fpend_q <= (fpend_q & ~fclr) | fall_ev;
      evt_q   <= (rise_ev | fall_ev | sw_ev) & emr_q;
    end
  end

  assign regs_o = '{rsel: rsel_q, fsel: fsel_q, rpend: rpend_q, fpend: fpend_q,
                    imr: imr_q, emr: emr_q};
  assign irq_o  = (rpend_q | fpend_q) & imr_q;
  assign evt_o  = evt_q;

  p_rise_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_ev) |=> ((rpend_q & $past(rise_ev)) == $past(rise_ev)));
  p_fall_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fall_ev) |=> ((fpend_q & $past(fall_ev)) == $past(fall_ev)));
  p_rpend_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i.rclr) |=> ((rpend_q & $past(rpend_q)) == $past(rpend_q)));
  p_fpend_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i.fclr) |=> ((fpend_q & $past(fpend_q)) == $past(fpend_q)));
  p_swt_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i.swt && |(wdata_i & rsel_q)) |=>
      ((rpend_q & $past(wdata_i & rsel_q)) == $past(wdata_i & rsel_q)));
  p_absent_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rsel_q | fsel_q | rpend_q | fpend_q | imr_q | emr_q) & ~IMPL) == '0);
endmodule

// File: rtl/ext_irq_ctrl.sv
`timescale 1ns/1ps
module ext_irq_ctrl import exti_pkg::*; #(
  parameter int NUM_BANKS   = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0] IMPL_MASK =
    {32'h0000_03FF, 32'h00FF_FFFF, 32'hFFFF_FFFF},
  localparam int NUM_LINES = NUM_BANKS * BANK_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [BANK_W-1:0]    reg_wdata_i,
  output logic [BANK_W-1:0]    reg_rdata_o,
  output logic [NUM_LINES-1:0] irq_o,
  output logic                 irq_any_o,
  output logic [NUM_LINES-1:0] evt_o
);
  localparam int WR_BITS = $bits(bank_wr_t);

  logic                  hit;
  logic [BANK_IDX_W-1:0] bank_sel;
  reg_e                  reg_sel;
  bank_wr_t              bank_wr   [NUM_BANKS];
  bank_regs_t            bank_regs [NUM_BANKS];
  logic [NUM_BANKS*WR_BITS-1:0] all_wr;

  exti_decode #(.NUM_BANKS(NUM_BANKS)) i_decode (
    .addr_i(reg_addr_i),
    .hit_o (hit),
    .bank_o(bank_sel),
    .reg_o (reg_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = reg_wr_i && hit && (bank_sel == BANK_IDX_W'(b));
    assign bank_wr[b] = '{rsel: sel && reg_sel == REG_RSEL,
                          fsel: sel && reg_sel == REG_FSEL,
                          swt:  sel && reg_sel == REG_SWT,
                          rclr: sel && reg_sel == REG_RPEND,
                          fclr: sel && reg_sel == REG_FPEND,
                          imr:  sel && reg_sel == REG_IMR,
                          emr:  sel && reg_sel == REG_EMR};
    assign all_wr[b*WR_BITS +: WR_BITS] = bank_wr[b];

    exti_bank #(
      .IMPL  (IMPL_MASK[b*BANK_W +: BANK_W]),
      .STAGES(SYNC_STAGES)
    ) i_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_i[b*BANK_W +: BANK_W]),
      .wr_i   (bank_wr[b]),
      .wdata_i(reg_wdata_i),
      .regs_o (bank_regs[b]),
      .irq_o  (irq_o[b*BANK_W +: BANK_W]),
      .evt_o  (evt_o[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit && bank_sel == BANK_IDX_W'(b)) begin
        unique case (reg_sel)
          REG_RSEL:  reg_rdata_o = bank_regs[b].rsel;
          REG_FSEL:  reg_rdata_o = bank_regs[b].fsel;
          REG_RPEND: reg_rdata_o = bank_regs[b].rpend;
          REG_FPEND: reg_rdata_o = bank_regs[b].fpend;
          REG_IMR:   reg_rdata_o = bank_regs[b].imr;
          REG_EMR:   reg_rdata_o = bank_regs[b].emr;
          default:   reg_rdata_o = '0;
        endcase
      end
    end
  end

  assign irq_any_o = |irq_o;

  p_one_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(all_wr));
  p_no_strobe_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_wr_i || !hit) |-> (all_wr == '0));
endmodule

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;
  localparam int NB = 3;
  localparam int NL = 96;
  localparam logic [31:0] IMPL [NB] = '{32'hFFFF_FFFF, 32'h00FF_FFFF, 32'h0000_03FF};
  localparam int O_RSEL = 0, O_FSEL = 4, O_SWT = 8, O_RP = 12, O_FP = 16;
  localparam int O_IMR = 0, O_EMR = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NL-1:0] lines = '0;
  logic          reg_wr = 0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] irq, evt;
  logic          irq_any;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_rsel [NB], m_fsel [NB], m_imr [NB], m_emr [NB], m_rp [NB], m_fp [NB];
  logic [NL-1:0] m_line;

  always #10 clk = ~clk;

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .line_i(lines), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .irq_any_o(irq_any), .evt_o(evt)
  );

  function automatic logic [7:0] ta(int b, int off); return 8'(b * 32 + off); endfunction
  function automatic logic [7:0] ma(int b, int off); return 8'(128 + b * 16 + off); endfunction

  function automatic logic [NL-1:0] exp_irq();
    logic [NL-1:0] v;
    for (int b = 0; b < NB; b++) v[b*32 +: 32] = (m_rp[b] | m_fp[b]) & m_imr[b];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [NL-1:0] got, input logic [NL-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, NL'(reg_rdata), NL'(exp));
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic drive_lines(input logic [NL-1:0] v);
    @(negedge clk);
    lines = v;
    settle();
  endtask

  task automatic model_lines(input logic [NL-1:0] v);
    for (int b = 0; b < NB; b++) begin
      m_rp[b] |= v[b*32 +: 32] & ~m_line[b*32 +: 32] & m_rsel[b];
      m_fp[b] |= ~v[b*32 +: 32] & m_line[b*32 +: 32] & m_fsel[b];
    end
    m_line = v;
  endtask

  task automatic check_all(input string tag);
    for (int b = 0; b < NB; b++) begin
      rd_chk({tag, " R2 rsel"}, ta(b, O_RSEL), m_rsel[b]);
      rd_chk({tag, " R2 fsel"}, ta(b, O_FSEL), m_fsel[b]);
      rd_chk({tag, " R3 rpend"}, ta(b, O_RP), m_rp[b]);
      rd_chk({tag, " R4 fpend"}, ta(b, O_FP), m_fp[b]);
      rd_chk({tag, " R2 imr"}, ma(b, O_IMR), m_imr[b]);
      rd_chk({tag, " R2 emr"}, ma(b, O_EMR), m_emr[b]);
    end
    chk({tag, " R10 irq"}, irq, exp_irq());
    chk({tag, " R11 any"}, NL'(irq_any), NL'(|exp_irq()));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int b = 0; b < NB; b++) begin
      for (int o = 0; o <= 16; o += 4) rd_chk("R1 trig reg", ta(b, o), 32'h0);
      rd_chk("R1 imr", ma(b, O_IMR), 32'h0);
      rd_chk("R1 emr", ma(b, O_EMR), 32'h0);
    end
    chk("R1 irq", irq, '0);
    chk("R1 any", NL'(irq_any), '0);
    chk("R1 evt", evt, '0);

    // R9 implemented lines
    for (int b = 0; b < NB; b++) begin
      wr(ta(b, O_RSEL), 32'hFFFF_FFFF);
      rd_chk("R9 rsel readback", ta(b, O_RSEL), IMPL[b]);
      wr(ta(b, O_FSEL), 32'hFFFF_FFFF);
      rd_chk("R9 fsel readback", ta(b, O_FSEL), IMPL[b]);
    end
    drive_lines(NL'(1) << 95);
    rd_chk("R9 absent line no pending", ta(2, O_RP), 32'h0);
    drive_lines('0);
    rd_chk("R9 absent line no fall pending", ta(2, O_FP), 32'h0);
    for (int b = 0; b < NB; b++) begin
      wr(ta(b, O_RSEL), 0);
      wr(ta(b, O_FSEL), 0);
    end

    // R2 unmapped addresses and word alignment
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped 0x60", 8'h60, 0);
    rd_chk("R2 unmapped 0xB0", 8'hB0, 0);
    rd_chk("R2 unmapped 0x88", 8'h88, 0);
    rd_chk("R2 unaligned 0x01", 8'h01, 0);
    rd_chk("R2 rsel untouched", ta(0, O_RSEL), 0);

    // R3 latency, R10, R11, R12 on line 3
    wr(ta(0, O_RSEL), 32'h8);
    wr(ma(0, O_IMR), 32'h8);
    wr(ma(0, O_EMR), 32'h8);
    @(negedge clk); reg_addr = ta(0, O_RP); lines[3] = 1;
    @(negedge clk);
    @(negedge clk); #1;
    chk("R3 not yet after two edges", NL'(reg_rdata), 0);
    chk("R12 no early event", evt, '0);
    @(negedge clk); #1;
    chk("R3 rising pending", NL'(reg_rdata), NL'(32'h8));
    chk("R10 irq line 3", NL'(irq[3]), 1);
    chk("R11 any high", NL'(irq_any), 1);
    chk("R12 event pulse", evt, NL'(32'h8));
    @(negedge clk); #1;
    chk("R12 event one cycle", evt, '0);

    // R5 falling edge without select, R4 both edges
    drive_lines('0);
    rd_chk("R5 fall not selected", ta(0, O_FP), 0);
    wr(ta(0, O_RP), 32'h8);
    rd_chk("R6 rise cleared", ta(0, O_RP), 0);
    wr(ta(0, O_FSEL), 32'h8);
    drive_lines(NL'(32'h8));
    drive_lines('0);
    rd_chk("R4 both rise", ta(0, O_RP), 32'h8);
    rd_chk("R4 both fall", ta(0, O_FP), 32'h8);

    // R6 write-1-to-clear
    wr(ta(0, O_RP), 0);
    rd_chk("R6 zero write keeps", ta(0, O_RP), 32'h8);
    wr(ta(0, O_RP), 32'h8);
    rd_chk("R6 rise cleared", ta(0, O_RP), 0);
    rd_chk("R6 fall independent", ta(0, O_FP), 32'h8);
    chk("R10 irq from fall pending", NL'(irq[3]), 1);
    wr(ta(0, O_FP), 32'h8);
    rd_chk("R6 fall cleared", ta(0, O_FP), 0);
    chk("R10 irq low", irq, '0);
    chk("R11 any low", NL'(irq_any), 0);

    // R7 edge meets clear on the same clock edge, line 6
    wr(ta(0, O_RSEL), 32'h48);
    @(negedge clk); lines[6] = 1;
    @(negedge clk);
    @(negedge clk); reg_wr = 1; reg_addr = ta(0, O_RP); reg_wdata = 32'h40;
    @(negedge clk); reg_wr = 0;
    rd_chk("R7 edge wins over clear", ta(0, O_RP), 32'h40);
    wr(ta(0, O_RP), 32'h40);
    rd_chk("R7 later clear works", ta(0, O_RP), 0);
    drive_lines('0);

    // R10 masked line latches, line 40
    wr(ta(1, O_RSEL), 32'h100);
    drive_lines(NL'(1) << 40);
    rd_chk("R10 masked latches", ta(1, O_RP), 32'h100);
    chk("R10 masked no irq", NL'(irq[40]), 0);
    chk("R11 any low when masked", NL'(irq_any), 0);
    wr(ma(1, O_IMR), 32'h100);
    #1;
    chk("R10 unmask asserts", NL'(irq[40]), 1);
    chk("R11 any follows", NL'(irq_any), 1);

    // R8 software trigger, R12 event from trigger
    wr(ta(2, O_RSEL), 32'h1);
    wr(ta(2, O_SWT), 32'h3);
    rd_chk("R8 trigger sets selected", ta(2, O_RP), 32'h1);
    rd_chk("R8 trigger reads zero", ta(2, O_SWT), 0);
    wr(ta(2, O_RP), 32'h1);
    wr(ta(2, O_SWT), 0);
    rd_chk("R8 zero write no effect", ta(2, O_RP), 0);
    wr(ma(2, O_EMR), 32'h1);
    wr(ta(2, O_SWT), 32'h1);
    #1;
    chk("R12 trigger event", NL'(evt[64]), 1);
    @(negedge clk); #1;
    chk("R12 trigger event one cycle", NL'(evt[64]), 0);

    // clean state
    drive_lines('0);
    for (int b = 0; b < NB; b++) begin
      wr(ta(b, O_RSEL), 0); wr(ta(b, O_FSEL), 0);
      wr(ma(b, O_IMR), 0);  wr(ma(b, O_EMR), 0);
      wr(ta(b, O_RP), '1);  wr(ta(b, O_FP), '1);
      m_rsel[b] = 0; m_fsel[b] = 0; m_imr[b] = 0; m_emr[b] = 0; m_rp[b] = 0; m_fp[b] = 0;
    end
    m_line = '0;
    check_all("clean");

    // random phase
    for (int it = 0; it < 60; it++) begin
      int op, b, k;
      logic [31:0] d;
      op = $urandom_range(0, 4);
      b  = $urandom_range(0, NB - 1);
      d  = $urandom;
      case (op)
        0: begin
          k = $urandom_range(0, 3);
          case (k)
            0: begin wr(ta(b, O_RSEL), d); m_rsel[b] = d & IMPL[b]; end
            1: begin wr(ta(b, O_FSEL), d); m_fsel[b] = d & IMPL[b]; end
            2: begin wr(ma(b, O_IMR), d);  m_imr[b]  = d & IMPL[b]; end
            default: begin wr(ma(b, O_EMR), d); m_emr[b] = d & IMPL[b]; end
          endcase
        end
        1, 2: begin
          logic [NL-1:0] nv;
          nv = {$urandom, $urandom, $urandom};
          drive_lines(nv);
          model_lines(nv);
        end
        3: begin
          if (d[0]) begin wr(ta(b, O_RP), d); m_rp[b] &= ~d; end
          else begin wr(ta(b, O_FP), d); m_fp[b] &= ~d; end
        end
        default: begin
          wr(ta(b, O_SWT), d);
          m_rp[b] |= d & m_rsel[b];
        end
      endcase
      settle();
      check_all("random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule